// File: doc/BRIEF.md
# Triggered Waveform Capture with Ping-Pong Event Buffers

This block writes every accepted sample into a circular delay pipeline. When a trigger pulse arrives, it looks back by a programmable number of samples and copies a fixed window of consecutive samples into the event buffer that is currently filling. Each stored event is one header word followed by the window samples. The header carries a running event number and a cycle timestamp.

There are two event buffers. One fills with triggered events while the other is presented on a valid/ready readout port, one word per accepted transfer. The roles swap when the filling buffer reaches its event limit, or when a spill-end flush has been requested. A swap waits until the readout buffer is fully drained. Triggers that cannot be served are counted and otherwise ignored: a trigger during a copy, or a trigger while the filling buffer is full.

In deployment the pipeline holds 8,000 to 51,200 samples and the window is 64 samples. Each buffer holds 128 events, and samples are 12 bits at 125 MHz. The defaults are smaller so that elaboration stays light.

Top module: `trig_capture`

## Requirements
- R1: After synchronous reset, `drained` is 1, `m_valid` is 0, `full` is 0 and `drop_cnt` is 0. The event number and the timestamp restart from 0.
- R2: A trigger accepted at a clock edge where n samples had been accepted before it stores the samples with indices n-`lat` through n-`lat`+WIN-1 (index 0 is the first sample after reset). This holds for WIN <= `lat` <= DEPTH-2.
- R3: Each event is read out as WIN+1 words. Word 0 is the header, with the event number (0 for the first accepted trigger after reset, then +1 per accepted trigger) in bits [CW+TW-1:TW] and the timestamp in bits [TW-1:0]. The timestamp equals the number of clock edges since reset left. Words 1..WIN are the samples zero-extended, in time order. `m_hdr` is 1 exactly while word 0 is presented.
- R4: A trigger that arrives while a copy is in progress (the WIN edges after an accepted trigger) is dropped. It increments `drop_cnt` by 1, and the copy in progress completes unchanged.
- R5: The filling buffer is handed to readout once it holds MAX_EV events and the readout buffer is drained. Events are read out in trigger order.
- R6: A one-cycle `flush` pulse is held pending. It hands over a partly filled, non-empty buffer as soon as no copy is running and the readout buffer is drained. Without a flush, a partly filled buffer is never presented.
- R7: While the filling buffer holds MAX_EV events and the readout buffer is not drained, `full` is 1 and stays 1 until the swap. Every trigger in that time is dropped and counted in `drop_cnt`.
- R8: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` is unchanged. Exactly one word is consumed per edge with `m_valid` and `m_ready` both 1.
- R9: `drained` rises at the edge that consumes the last word of the last event in the readout buffer.
- R10: Capture into one buffer continues while the other buffer is waiting for or undergoing readout, and no event from either buffer is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | SW | Sample word |
| s_valid | input | 1 | Sample strobe; each strobe writes one pipeline slot |
| trig | input | 1 | Trigger pulse |
| lat | input | PW | Lookback latency in samples |
| flush | input | 1 | Spill-end request to hand over a partial buffer |
| m_ready | input | 1 | Readout consumer ready |
| m_data | output | CW+TW | Readout word (header or zero-extended sample) |
| m_valid | output | 1 | Readout word valid |
| m_hdr | output | 1 | Current word is an event header |
| drained | output | 1 | Readout buffer holds no unread word |
| full | output | 1 | Filling buffer at its event limit |
| drop_cnt | output | CW | Count of dropped triggers |

## Verification
The assertions check several rules on every cycle. The readout word must hold steady under back-pressure. A swap may occur only out of a drained state. The full flag must persist until a swap. A trigger during a copy must bump the drop count, and the copy index must stay inside the window. Whether the copied window holds the right samples for a given latency can only be shown by the directed scenarios. The same holds for header numbering and timestamps, event ordering across swaps, the deferred swap after a flush, and the capture of a second buffer while the first is still unread.

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int SW = 12,
  parameter int DEPTH = 1024,
  parameter int WIN = 64,
  parameter int MAX_EV = 8,
  parameter int CW = 16,
  parameter int TW = 16,
  localparam int OW = CW + TW,
  localparam int PW = $clog2(DEPTH),
  localparam int SLOT = WIN + 1,
  localparam int EW = $clog2(MAX_EV + 1),
  localparam int EIW = $clog2(MAX_EV),
  localparam int WW = $clog2(WIN + 1),
  localparam int BAW = $clog2(2 * MAX_EV * SLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] s_data,
  input  logic          s_valid,
  input  logic          trig,
  input  logic [PW-1:0] lat,
  input  logic          flush,
  input  logic          m_ready,
  output logic [OW-1:0] m_data,
  output logic          m_valid,
  output logic          m_hdr,
  output logic          drained,
  output logic          full,
  output logic [CW-1:0] drop_cnt
);

  logic [SW-1:0] pipe [DEPTH];
  logic [OW-1:0] evb [2*MAX_EV*SLOT];
  logic [PW-1:0] wptr, raddr, start;
  logic          busy, fsel, pend;
  logic [WW-1:0] cidx, rd_w;
  logic [EW-1:0] fcnt, rcnt;
  logic [EIW-1:0] rd_ev;
  logic [CW-1:0] evcnt;
  logic [TW-1:0] ts;
  logic          trig_ok, swap_ok, take;

  function automatic logic [BAW-1:0] ba(input logic s, input int e, input int w);
    return BAW'((int'(s) * MAX_EV + e) * SLOT + w);
  endfunction

  assign full    = fcnt == EW'(MAX_EV);
  assign drained = rcnt == '0;
  assign m_valid = !drained;
  assign m_hdr   = m_valid && rd_w == '0;
  assign take    = m_valid && m_ready;
  assign trig_ok = trig && !busy && !full;
  assign swap_ok = (full || (pend && fcnt != '0)) && !busy && drained && !trig_ok;
  assign start   = (wptr >= lat) ? wptr - lat : PW'(int'(wptr) + DEPTH - int'(lat));
  assign m_data  = evb[ba(!fsel, int'(rd_ev), int'(rd_w))];

  always_ff @(posedge clk)
    if (s_valid) pipe[wptr] <= s_data;

  always_ff @(posedge clk)
    if (trig_ok) evb[ba(fsel, int'(fcnt), 0)] <= {evcnt, ts};
    else if (busy) evb[ba(fsel, int'(fcnt), int'(cidx) + 1)] <= OW'(pipe[raddr]);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; raddr <= '0; busy <= 1'b0; cidx <= '0; pend <= 1'b0;
      fsel <= 1'b0; fcnt <= '0; rcnt <= '0; rd_ev <= '0; rd_w <= '0;
      evcnt <= '0; ts <= '0; drop_cnt <= '0;
    end else begin
      ts <= ts + 1'b1;
      if (s_valid) wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
      if (trig && !trig_ok) drop_cnt <= drop_cnt + 1'b1;
      pend <= (pend || flush) && !swap_ok;
      if (trig_ok) begin
        busy <= 1'b1; cidx <= '0; raddr <= start; evcnt <= evcnt + 1'b1;
      end else if (busy) begin
        raddr <= (int'(raddr) == DEPTH - 1) ? '0 : raddr + 1'b1;
        cidx <= cidx + 1'b1;
        if (int'(cidx) == WIN - 1) begin
          busy <= 1'b0;
          fcnt <= fcnt + 1'b1;
        end
      end
      if (swap_ok) begin
        fsel <= !fsel; rcnt <= fcnt; fcnt <= '0; rd_ev <= '0; rd_w <= '0;
      end else if (take) begin
        if (int'(rd_w) == WIN) begin
          rd_w <= '0;
          if (int'(rd_ev) == int'(rcnt) - 1) begin
            rcnt <= '0; rd_ev <= '0;
          end else rd_ev <= rd_ev + 1'b1;
        end else rd_w <= rd_w + 1'b1;
      end
    end
  end

  p_copy_len_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> int'(cidx) < WIN);
  p_busy_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && trig) |=> drop_cnt == $past(drop_cnt) + 1'b1);
  p_swap_drained_r5: assert property (@(posedge clk) disable iff (rst)
    (fsel != $past(fsel)) |-> $past(drained));
  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    full |=> (full || fsel != $past(fsel)));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_last_r9: assert property (@(posedge clk) disable iff (rst)
    (take && int'(rd_w) == WIN && int'(rd_ev) == int'(rcnt) - 1) |=> drained);

endmodule

// File: tb/trig_capture_bench.sv
module trig_capture_bench;
  localparam int SW = 12, DEPTH = 64, WIN = 8, MAX_EV = 4, CW = 16, TW = 16;
  localparam int OW = CW + TW, PW = 6, LAT = 20;

  logic clk = 1'b0, rst = 1'b1, s_valid = 1'b0, trig = 1'b0, flush = 1'b0, m_ready = 1'b0;
  logic [SW-1:0] s_data;
  logic [PW-1:0] lat = PW'(LAT);
  logic [OW-1:0] m_data;
  logic m_valid, m_hdr, drained, full;
  logic [CW-1:0] drop_cnt;

  int checks = 0, fails = 0, nsamp = 0, cyc = 0, exp_ev = 0, exp_drop = 0;
  int q_n[$], q_c[$], q_e[$];

  always #5 clk = ~clk;

  trig_capture #(.SW(SW), .DEPTH(DEPTH), .WIN(WIN), .MAX_EV(MAX_EV), .CW(CW), .TW(TW)) u_trig_capture (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .trig(trig), .lat(lat),
    .flush(flush), .m_ready(m_ready), .m_data(m_data), .m_valid(m_valid), .m_hdr(m_hdr),
    .drained(drained), .full(full), .drop_cnt(drop_cnt));

  assign s_data = SW'(nsamp);

  always @(posedge clk)
    if (rst) begin nsamp <= 0; cyc <= 0; end
    else begin cyc <= cyc + 1; if (s_valid) nsamp <= nsamp + 1; end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic gap(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic fire(input bit acc);
    trig = 1'b1;
    if (acc) begin q_n.push_back(nsamp); q_c.push_back(cyc); q_e.push_back(exp_ev); exp_ev++; end
    else exp_drop++;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic read_events(input int nev, input bit bp);
    m_ready = 1'b1;
    for (int e = 0; e < nev; e++) begin
      int n = q_n.pop_front(), c = q_c.pop_front(), ev = q_e.pop_front();
      for (int w = 0; w <= WIN; w++) begin
        int t = 0;
        logic [OW-1:0] exp;
        while (!m_valid && t < 300) begin @(negedge clk); t++; end
        if (bp && e == 0 && w == 3) begin
          logic [OW-1:0] hold = m_data;
          m_ready = 1'b0;
          repeat (3) begin
            @(negedge clk);
            chk(m_valid && m_data == hold, "R8", "held word", m_data, hold);
          end
          m_ready = 1'b1;
        end
        exp = (w == 0) ? {CW'(ev), TW'(c)} : OW'(SW'(n - LAT + w - 1));
        chk(m_valid && m_data == exp, w == 0 ? "R3" : "R2", "event word", m_data, exp);
        chk(m_hdr == (w == 0), "R3", "header flag", m_hdr, w == 0);
        @(negedge clk);
      end
    end
    m_ready = 1'b0;
    chk(drained, "R9", "drained after last word", drained, 1);
  endtask

  task automatic t_reset;
    chk(drained && !m_valid, "R1", "drained/valid", {drained, m_valid}, 2'b10);
    chk(!full, "R1", "full", full, 0);
    chk(drop_cnt == 0, "R1", "drop count", drop_cnt, 0);
  endtask

  task automatic t_basic;
    fire(1); gap(3); fire(0);
    gap(WIN + 2);
    chk(drop_cnt == CW'(exp_drop), "R4", "drop during copy", drop_cnt, exp_drop);
    for (int i = 0; i < MAX_EV - 1; i++) begin fire(1); gap(WIN + 3 + i); end
    read_events(MAX_EV, 1'b0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 2 * MAX_EV; i++) begin fire(1); gap(WIN + 2); end
    gap(4);
    chk(full, "R7", "full while readout pending", full, 1);
    fire(0); gap(3);
    chk(drop_cnt == CW'(exp_drop), "R7", "drop while full", drop_cnt, exp_drop);
    chk(full, "R7", "full held", full, 1);
    read_events(MAX_EV, 1'b1);
    gap(3);
    chk(!full && m_valid, "R10", "second buffer handed over", {full, m_valid}, 2'b01);
    read_events(MAX_EV, 1'b0);
  endtask

  task automatic t_flush;
    fire(1); gap(WIN + 2); fire(1); gap(WIN + 4);
    chk(!m_valid, "R6", "partial buffer not presented", m_valid, 0);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    gap(3);
    chk(m_valid, "R6", "flush hands over", m_valid, 1);
    read_events(2, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", checks, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    gap(4);
    rst = 1'b0; s_valid = 1'b1;
    @(negedge clk);
    t_reset();
    gap(30);
    t_basic();
    t_full();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule